// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 64-bit virtual address into a physical address. It reads up to three 64-bit translation entries through a simple read port that is held until the read data is marked valid. Each request gives the address, a mask of the access kinds needed (read, write or execute, or none at all for a debug probe), and a privilege bit (kernel or user). The block checks first that the address is properly sign-extended. A kernel superpage window is translated directly, with no memory traffic. Every other address is translated by walking the tables, starting from a table base input.

When the walk ends, the block gives a one-cycle completion pulse. With it come a success flag, a fault code, the physical address and the granted read/write/execute mask. The fault code tells apart a missing translation, an access violation, and the three fault-on-access conditions, which have a fixed priority among them. Translation caching and arbitration of the memory port belong to the surrounding logic.

Top module: `pt_walker`

## Requirements
- R1: The address is legal only when bits [63:43] all equal bit 63. An illegal address completes with ok low and fault code 1 (access violation), and issues no memory read.
- R2: A legal address with bit 63 set and bits [42:41] equal to 2'b10 is a superpage. At kernel privilege it completes with ok high, prot 3'b111 and no memory read. Physical bits [39:0] are the virtual bits [39:0], physical bit 43 is virtual bit 40, and every other physical bit is zero.
- R3: A superpage address at user privilege completes with ok low, fault code 1, and no memory read.
- R4: Any other legal address makes up to three reads. The index at level n (n = 1..3) is bits [13+10*(3-n) +: 10]. The read address is the table base plus 8 times the index. Level 1 uses ptbr_i as its base. Each later base, and the final frame, is entry bits [63:32] shifted left by 13. The result is the frame with virtual bits [12:0] added as the page offset.
- R5: At levels 1 and 2, an entry with bit 0 (valid) clear ends the walk with fault 0 (not valid). An entry with bit 8 (kernel read) clear ends it with fault 1. No further read is made in either case.
- R6: A level-3 entry with bit 0 clear gives fault 0, whatever access is needed.
- R7: In the level-3 entry, bit 8 (kernel) or bit 9 (user) grants read and execute. Bit 12 (kernel) or bit 13 (user) grants write. If need is non-zero and none of its bits is granted, the result is fault 1. Need bits are read = 0, write = 1, execute = 2, and prot_o uses the same positions.
- R8: Entry bits 1, 2 and 3 take read, write and execute out of the grant. If need is non-zero and none of its bits survives, the fault is 3 when need includes execute, else 4 when it includes write, else 2.
- R9: A request with need zero succeeds whenever no valid-bit or kernel-read fault occurs on the walk. It returns the physical address and the masked grant.
- R10: done_o is high for exactly one cycle per accepted request, and ok_o, fault_o, paddr_o and prot_o are valid while it is high. prot_o is zero whenever ok_o is low.
- R11: A request is accepted only while ready_o is high. req_valid_i has no effect while a walk is in progress.
- R12: mem_req_o and mem_addr_o stay steady until mem_rvalid_i is seen, whatever the read latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Start a translation (sampled when ready_o is high) |
| req_vaddr_i | input | 64 | Virtual address |
| req_need_i | input | 3 | Needed access: bit 0 read, bit 1 write, bit 2 execute |
| req_user_i | input | 1 | 1 = user privilege, 0 = kernel |
| ptbr_i | input | 45 | Physical base of the level-1 table |
| ready_o | output | 1 | Idle and able to accept a request |
| mem_req_o | output | 1 | Entry read request |
| mem_addr_o | output | 45 | Entry read address |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 64 | Entry read data |
| done_o | output | 1 | Completion pulse |
| ok_o | output | 1 | Translation succeeded |
| fault_o | output | 3 | Fault code: 0 not valid, 1 access violation, 2 read, 3 execute, 4 write |
| paddr_o | output | 45 | Physical address |
| prot_o | output | 3 | Granted access: bit 0 read, bit 1 write, bit 2 execute |

## Verification
A small fixed table tree is loaded into the memory model. Level-3 entries cover full access, kernel-read-only access, all fault-on bits set, only fault-on-execute set, and an invalid entry. Single-bit, multi-bit and zero need masks at both privileges separate the grant stage from the masking stage, and show the execute-over-write-over-read priority. Missing and kernel-read-less entries at levels 1 and 2, counted against the expected number of reads, show where the walk stops. Non-extended addresses, both superpage variants of bit 40, a superpage at user privilege, and a negative address just outside the window separate the bypass from the walk. The whole table runs at zero and at three cycles of read latency, and a request pulsed during a walk is checked to leave no trace.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [2:0] {
    FLT_TNV = 3'd0,
    FLT_ACV = 3'd1,
    FLT_FOR = 3'd2,
    FLT_FOE = 3'd3,
    FLT_FOW = 3'd4
  } fault_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SUPER,
    ST_WALK,
    ST_CHECK,
    ST_DONE
  } state_e;

  localparam int PTE_V   = 0;
  localparam int PTE_FOR = 1;
  localparam int PTE_FOW = 2;
  localparam int PTE_FOE = 3;
  localparam int PTE_KRE = 8;
  localparam int PTE_URE = 9;
  localparam int PTE_KWE = 12;
  localparam int PTE_UWE = 13;

  localparam int ACC_R = 0;
  localparam int ACC_W = 1;
  localparam int ACC_X = 2;
endpackage

// File: rtl/ptw_va_check.sv
module ptw_va_check #(
  parameter int VA_BITS = 43,
  parameter int PA_W    = 45,
  parameter int SP_LOW  = 40,
  parameter int SP_HIGH = 43
) (
  input  logic [63:0]     va_i,
  output logic            legal_o,
  output logic            super_o,
  output logic [PA_W-1:0] super_pa_o
);
  assign legal_o = (va_i[63:VA_BITS] == {(64-VA_BITS){va_i[63]}});
  assign super_o = va_i[63] & (va_i[VA_BITS-1:VA_BITS-2] == 2'b10);

  // superpage keeps the low window and relocates its top bit
  always_comb begin
    super_pa_o                = '0;
    super_pa_o[SP_LOW-1:0]    = va_i[SP_LOW-1:0];
    super_pa_o[SP_HIGH]       = va_i[SP_LOW];
  end
endmodule

// File: rtl/ptw_perm.sv
module ptw_perm
  import ptw_pkg::*;
#(
  parameter int PTE_W = 64
) (
  input  logic [PTE_W-1:0] pte_i,
  input  logic [2:0]       need_i,
  input  logic             user_i,
  output logic             ok_o,
  output fault_e           fault_o,
  output logic [2:0]       prot_o
);
  logic       rd_en, wr_en;
  logic [2:0] grant, fo_mask, masked;
  logic       unused_pte;

  assign rd_en = user_i ? pte_i[PTE_URE] : pte_i[PTE_KRE];
  assign wr_en = user_i ? pte_i[PTE_UWE] : pte_i[PTE_KWE];

  always_comb begin
    grant        = '0;
    grant[ACC_R] = rd_en;
    grant[ACC_W] = wr_en;
    grant[ACC_X] = rd_en;
    fo_mask        = '0;
    fo_mask[ACC_R] = pte_i[PTE_FOR];
    fo_mask[ACC_W] = pte_i[PTE_FOW];
    fo_mask[ACC_X] = pte_i[PTE_FOE];
  end

  assign masked = grant & ~fo_mask;

  always_comb begin
    ok_o    = 1'b0;
    fault_o = FLT_TNV;
    prot_o  = '0;
    if (!pte_i[PTE_V]) begin
      fault_o = FLT_TNV;
    end else if ((need_i != '0) && ((grant & need_i) == '0)) begin
      fault_o = FLT_ACV;
    end else if ((need_i != '0) && ((masked & need_i) == '0)) begin
      if (need_i[ACC_X])      fault_o = FLT_FOE;
      else if (need_i[ACC_W]) fault_o = FLT_FOW;
      else                    fault_o = FLT_FOR;
    end else begin
      ok_o   = 1'b1;
      prot_o = masked;
    end
  end

  assign unused_pte = ^{pte_i[PTE_W-1:14], pte_i[11:10], pte_i[7:4]};
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
#(
  parameter int PAGE_BITS = 13,
  parameter int IDX_W     = 10,
  parameter int LEVELS    = 3,
  parameter int PFN_W     = 32,
  parameter int PTE_W     = 64,
  parameter int SP_LOW    = 40,
  parameter int SP_HIGH   = 43,
  localparam int VA_BITS  = PAGE_BITS + IDX_W * LEVELS,
  localparam int PA_W     = PFN_W + PAGE_BITS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [63:0]      req_vaddr_i,
  input  logic [2:0]       req_need_i,
  input  logic             req_user_i,
  input  logic [PA_W-1:0]  ptbr_i,
  output logic             ready_o,
  output logic             mem_req_o,
  output logic [PA_W-1:0]  mem_addr_o,
  input  logic             mem_rvalid_i,
  input  logic [PTE_W-1:0] mem_rdata_i,
  output logic             done_o,
  output logic             ok_o,
  output logic [2:0]       fault_o,
  output logic [PA_W-1:0]  paddr_o,
  output logic [2:0]       prot_o
);
  localparam int LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1;
  localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(LEVELS - 1);
  localparam int ADDR_PAD = PA_W - IDX_W - 3;

  state_e             state_q;
  logic [LVL_W-1:0]   lvl_q;
  logic [VA_BITS-1:0] va_q;
  logic [2:0]         need_q;
  logic               user_q;
  logic [PA_W-1:0]    base_q;
  logic [PTE_W-1:0]   pte_q;
  logic               res_ok_q;
  fault_e             res_fault_q;
  logic [PA_W-1:0]    res_pa_q;
  logic [2:0]         res_prot_q;

  logic               va_legal, va_super;
  logic [PA_W-1:0]    super_pa;
  logic               chk_ok;
  fault_e             chk_fault;
  logic [2:0]         chk_prot;
  logic [IDX_W-1:0]   idx_arr [LEVELS];
  logic [PA_W-1:0]    next_base, frame_pa;

  ptw_va_check #(
    .VA_BITS (VA_BITS),
    .PA_W    (PA_W),
    .SP_LOW  (SP_LOW),
    .SP_HIGH (SP_HIGH)
  ) u_va_check (
    .va_i       (req_vaddr_i),
    .legal_o    (va_legal),
    .super_o    (va_super),
    .super_pa_o (super_pa)
  );

  ptw_perm #(.PTE_W(PTE_W)) u_perm (
    .pte_i   (pte_q),
    .need_i  (need_q),
    .user_i  (user_q),
    .ok_o    (chk_ok),
    .fault_o (chk_fault),
    .prot_o  (chk_prot)
  );

  // level 1 takes the highest index field
  for (genvar g = 0; g < LEVELS; g++) begin : g_idx
    assign idx_arr[g] = va_q[PAGE_BITS + IDX_W*(LEVELS-1-g) +: IDX_W];
  end

  assign next_base  = {mem_rdata_i[PTE_W-1 -: PFN_W], {PAGE_BITS{1'b0}}};
  assign frame_pa   = {pte_q[PTE_W-1 -: PFN_W], va_q[PAGE_BITS-1:0]};
  assign mem_addr_o = base_q + {{ADDR_PAD{1'b0}}, idx_arr[lvl_q], 3'b000};
  assign mem_req_o  = (state_q == ST_WALK);
  assign ready_o    = (state_q == ST_IDLE);
  assign done_o     = (state_q == ST_DONE);
  assign ok_o       = res_ok_q;
  assign fault_o    = res_fault_q;
  assign paddr_o    = res_pa_q;
  assign prot_o     = res_prot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      lvl_q       <= '0;
      va_q        <= '0;
      need_q      <= '0;
      user_q      <= 1'b0;
      base_q      <= '0;
      pte_q       <= '0;
      res_ok_q    <= 1'b0;
      res_fault_q <= FLT_TNV;
      res_pa_q    <= '0;
      res_prot_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid_i) begin
            va_q        <= req_vaddr_i[VA_BITS-1:0];
            need_q      <= req_need_i;
            user_q      <= req_user_i;
            base_q      <= ptbr_i;
            lvl_q       <= '0;
            res_ok_q    <= 1'b0;
            res_fault_q <= FLT_ACV;
            res_pa_q    <= '0;
            res_prot_q  <= '0;
            if (!va_legal) begin
              state_q <= ST_DONE;
            end else if (va_super) begin
              res_pa_q <= super_pa;
              state_q  <= ST_SUPER;
            end else begin
              state_q <= ST_WALK;
            end
          end
        end
        ST_SUPER: begin
          if (user_q) begin
            res_pa_q <= '0;
          end else begin
            res_ok_q   <= 1'b1;
            res_prot_q <= 3'b111;
          end
          state_q <= ST_DONE;
        end
        ST_WALK: begin
          if (mem_rvalid_i) begin
            if (lvl_q == LAST_LVL) begin
              pte_q   <= mem_rdata_i;
              state_q <= ST_CHECK;
            end else if (!mem_rdata_i[PTE_V]) begin
              res_fault_q <= FLT_TNV;
              state_q     <= ST_DONE;
            end else if (!mem_rdata_i[PTE_KRE]) begin
              res_fault_q <= FLT_ACV;
              state_q     <= ST_DONE;
            end else begin
              base_q <= next_base;
              lvl_q  <= lvl_q + LVL_W'(1);
            end
          end
        end
        ST_CHECK: begin
          res_ok_q    <= chk_ok;
          res_fault_q <= chk_fault;
          res_prot_q  <= chk_prot;
          res_pa_q    <= chk_ok ? frame_pa : '0;
          state_q     <= ST_DONE;
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ptw_checker.sv
module ptw_checker #(
  parameter int PA_W = 45
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            ready_o,
  input logic            mem_req_o,
  input logic [PA_W-1:0] mem_addr_o,
  input logic            mem_rvalid_i,
  input logic            done_o,
  input logic            ok_o,
  input logic [2:0]      fault_o,
  input logic [2:0]      prot_o
);
  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_prot_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !ok_o) |-> (prot_o == 3'b000));

  p_done_then_ready_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> ready_o);

  p_req_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_rvalid_i) |=> (mem_req_o && $stable(mem_addr_o)));

  p_idle_no_read_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> !mem_req_o);

  p_fault_code_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !ok_o) |-> (fault_o <= 3'd4));
endmodule

bind pt_walker ptw_checker #(.PA_W(PA_W)) u_ptw_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ready_o      (ready_o),
  .mem_req_o    (mem_req_o),
  .mem_addr_o   (mem_addr_o),
  .mem_rvalid_i (mem_rvalid_i),
  .done_o       (done_o),
  .ok_o         (ok_o),
  .fault_o      (fault_o),
  .prot_o       (prot_o)
);

// File: tb/tb_pt_walker.sv
module tb_pt_walker;
  localparam int PA_W = 45;
  localparam logic [PA_W-1:0] PTBR = 45'h10000;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            req_valid = 1'b0;
  logic [63:0]     req_vaddr = '0;
  logic [2:0]      req_need = '0;
  logic            req_user = 1'b0;
  logic            ready, mem_req, mem_rvalid, done, ok;
  logic [PA_W-1:0] mem_addr, paddr;
  logic [63:0]     mem_rdata;
  logic [2:0]      fault, prot;

  int checks = 0;
  int errors = 0;
  int lat = 0;
  int nreads = 0;
  int wcnt = 0;
  logic [63:0] pmem [logic [PA_W-1:0]];

  always #4 clk = ~clk;

  pt_walker dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_vaddr_i(req_vaddr),
    .req_need_i(req_need), .req_user_i(req_user), .ptbr_i(PTBR), .ready_o(ready),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_rvalid_i(mem_rvalid),
    .mem_rdata_i(mem_rdata), .done_o(done), .ok_o(ok), .fault_o(fault),
    .paddr_o(paddr), .prot_o(prot)
  );

  // read port model with programmable latency
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_rvalid <= 1'b0;
      mem_rdata  <= '0;
      wcnt       <= 0;
    end else begin
      mem_rvalid <= 1'b0;
      if (mem_req && !mem_rvalid) begin
        if (wcnt >= lat) begin
          mem_rvalid <= 1'b1;
          mem_rdata  <= pmem.exists(mem_addr) ? pmem[mem_addr] : 64'h0;
          nreads     <= nreads + 1;
          wcnt       <= 0;
        end else begin
          wcnt <= wcnt + 1;
        end
      end
    end
  end

  typedef struct packed {
    logic [63:0]     va;
    logic [2:0]      need;
    logic            user;
    logic            ok;
    logic [2:0]      fault;
    logic [PA_W-1:0] pa;
    logic [2:0]      prot;
    logic [1:0]      reads;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VECS [NV] = '{
    '{64'h2_0100_0123, 3'd1, 1'b1, 1'b1, 3'd0, 45'h200123, 3'd7, 2'd3},
    '{64'h2_0100_0123, 3'd2, 1'b0, 1'b1, 3'd0, 45'h200123, 3'd7, 2'd3},
    '{64'h2_0100_2123, 3'd2, 1'b0, 1'b0, 3'd1, 45'h0,      3'd0, 2'd3},
    '{64'h2_0100_2123, 3'd1, 1'b1, 1'b0, 3'd1, 45'h0,      3'd0, 2'd3},
    '{64'h2_0100_2123, 3'd4, 1'b0, 1'b1, 3'd0, 45'h202123, 3'd5, 2'd3},
    '{64'h2_0100_4123, 3'd1, 1'b0, 1'b0, 3'd2, 45'h0,      3'd0, 2'd3},
    '{64'h2_0100_4123, 3'd2, 1'b0, 1'b0, 3'd4, 45'h0,      3'd0, 2'd3},
    '{64'h2_0100_4123, 3'd4, 1'b0, 1'b0, 3'd3, 45'h0,      3'd0, 2'd3},
    '{64'h2_0100_4123, 3'd6, 1'b0, 1'b0, 3'd3, 45'h0,      3'd0, 2'd3},
    '{64'h2_0100_4123, 3'd3, 1'b0, 1'b0, 3'd4, 45'h0,      3'd0, 2'd3},
    '{64'h2_0100_4123, 3'd0, 1'b0, 1'b1, 3'd0, 45'h204123, 3'd0, 2'd3},
    '{64'h2_0100_6123, 3'd1, 1'b0, 1'b0, 3'd0, 45'h0,      3'd0, 2'd3},
    '{64'h2_0100_8123, 3'd4, 1'b0, 1'b0, 3'd3, 45'h0,      3'd0, 2'd3},
    '{64'h2_0100_8123, 3'd1, 1'b0, 1'b1, 3'd0, 45'h208123, 3'd3, 2'd3},
    '{64'h4_0000_0055, 3'd1, 1'b0, 1'b0, 3'd0, 45'h0,      3'd0, 2'd1},
    '{64'h6_0000_0000, 3'd1, 1'b0, 1'b0, 3'd1, 45'h0,      3'd0, 2'd1},
    '{64'h2_0280_0000, 3'd1, 1'b0, 1'b0, 3'd0, 45'h0,      3'd0, 2'd2},
    '{64'h0000_0800_0000_0000, 3'd1, 1'b0, 1'b0, 3'd1, 45'h0, 3'd0, 2'd0},
    '{64'h8000_0000_0000_0000, 3'd0, 1'b0, 1'b0, 3'd1, 45'h0, 3'd0, 2'd0},
    '{64'hFFFF_FD12_3456_789A, 3'd2, 1'b0, 1'b1, 3'd0, 45'h812_3456_789A, 3'd7, 2'd0},
    '{64'hFFFF_FC12_3456_789A, 3'd4, 1'b0, 1'b1, 3'd0, 45'h012_3456_789A, 3'd7, 2'd0},
    '{64'hFFFF_FD12_3456_789A, 3'd1, 1'b1, 1'b0, 3'd1, 45'h0, 3'd0, 2'd0},
    '{64'hFFFF_FE00_0000_0000, 3'd1, 1'b0, 1'b0, 3'd0, 45'h0, 3'd0, 2'd1},
    '{64'h2_0100_2123, 3'd0, 1'b0, 1'b1, 3'd0, 45'h202123, 3'd5, 2'd3},
    '{64'h2_0100_6123, 3'd0, 1'b0, 1'b0, 3'd0, 45'h0,      3'd0, 2'd3}
  };

  localparam string TAGS [NV] = '{
    "R4", "R4", "R7", "R7", "R7", "R8", "R8", "R8", "R8", "R8", "R9", "R6", "R8",
    "R8", "R5", "R5", "R5", "R1", "R1", "R2", "R2", "R3", "R1", "R9", "R6"
  };

  task automatic chk(input bit cond, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic run(input logic [63:0] va, input logic [2:0] need, input logic user,
                     output bit got, output int reads);
    int start;
    got = 1'b0;
    @(negedge clk);
    while (!ready) @(negedge clk);
    start     = nreads;
    req_vaddr = va;
    req_need  = need;
    req_user  = user;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 200; i++) begin
      if (done) begin
        got = 1'b1;
        break;
      end
      @(negedge clk);
    end
    reads = nreads - start;
  endtask

  task automatic run_table();
    for (int i = 0; i < NV; i++) begin
      bit got;
      int reads;
      run(VECS[i].va, VECS[i].need, VECS[i].user, got, reads);
      chk(got, TAGS[i], "done seen", 64'(got), 64'd1);
      chk(ok == VECS[i].ok, TAGS[i], "ok", 64'(ok), 64'(VECS[i].ok));
      if (VECS[i].ok) begin
        chk(paddr == VECS[i].pa, TAGS[i], "paddr", 64'(paddr), 64'(VECS[i].pa));
        chk(prot == VECS[i].prot, TAGS[i], "prot", 64'(prot), 64'(VECS[i].prot));
      end else begin
        chk(fault == VECS[i].fault, TAGS[i], "fault", 64'(fault), 64'(VECS[i].fault));
        chk(prot == 3'b000, "R10", "prot on fault", 64'(prot), 64'd0);
      end
      chk(reads == int'(VECS[i].reads), TAGS[i], "read count", 64'(reads),
          64'(VECS[i].reads));
      @(negedge clk);
      chk(!done, "R10", "done width", 64'(done), 64'd0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit got;
    int reads;
    int extra;
    pmem[45'h10008] = {32'h20, 32'h0000_0101};
    pmem[45'h10018] = {32'h22, 32'h0000_0001};
    pmem[45'h40010] = {32'h30, 32'h0000_0101};
    pmem[45'h60000] = {32'h100, 32'h0000_3301};
    pmem[45'h60008] = {32'h101, 32'h0000_0101};
    pmem[45'h60010] = {32'h102, 32'h0000_110F};
    pmem[45'h60018] = {32'h103, 32'h0000_3300};
    pmem[45'h60020] = {32'h104, 32'h0000_1109};

    repeat (3) @(negedge clk);
    // R10 reset state
    chk(ready && !done && !mem_req, "R10", "reset state",
        64'({ready, done, mem_req}), 64'b100);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    lat = 0;
    run_table();
    // R12 slow memory
    lat = 3;
    run_table();

    // R11 request pulsed during a walk is ignored
    lat = 2;
    @(negedge clk);
    req_vaddr = 64'h2_0100_0123;
    req_need  = 3'd1;
    req_user  = 1'b0;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (2) @(negedge clk);
    req_vaddr = 64'hFFFF_FD12_3456_789A;
    req_need  = 3'd2;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    got = 1'b0;
    for (int i = 0; i < 100; i++) begin
      if (done) begin
        got = 1'b1;
        break;
      end
      @(negedge clk);
    end
    chk(got && ok && paddr == 45'h200123, "R11", "first request result",
        64'(paddr), 64'h200123);
    extra = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (done) extra++;
    end
    chk(extra == 0, "R11", "no second completion", 64'(extra), 64'd0);

    // R12 back-to-back after the ignored pulse still translates
    run(64'h2_0100_2123, 3'd4, 1'b0, got, reads);
    chk(got && ok && prot == 3'd5, "R12", "walk after ignore", 64'(prot), 64'd5);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule